// File: doc/BRIEF.md
# Keyed Shutdown and Pad Sleep Controller

This block guards entry into the deepest power mode. Software requests shutdown by writing a 16-bit magic value into the key word of a small register bus. An exact match raises a one-cycle shutdown pulse and a level that stays high until a wakeup from reset or from an IO event arrives. Every other value is discarded and has no effect.

On entry the block forces the IO pads into their latched sleep state. On a wakeup from shutdown it keeps them latched, so that software can rebuild the IO configuration before it lets the pads follow the core again. It also records what caused the wakeup: a shutdown-exit flag, an IO-cause flag, and a two-bit wakeup source code. Software releases the pads by writing 1 to the pad-control bit, and that same write clears both shutdown flags. After an ordinary reset the pads start live, which is the state a normal boot leaves them in.

Register map (word index on `bus_addr`): 0 key word, 1 pad-control word, 2 wakeup source word, 3 shutdown flag word. Reads return data one cycle after the read request.

Top module: `pwr_sdn_ctrl`

## Requirements
- R1: After reset, pad-control bit 0 reads 1, `pad_sleep` is 0, `sdn_req` and `sdn_active` are 0, the flag word reads 0, and the wakeup source reads 1.
- R2: A write to word 0 whose bits [15:0] equal 0xA5A5 (bits [31:16] are don't-care) raises `sdn_req` for exactly one cycle after the write edge and sets `sdn_active` at that same edge.
- R3: A write to word 0 with any other value in bits [15:0] changes no output and no readable register.
- R4: At the edge where shutdown is entered, pad-control bit 0 becomes 0 and `pad_sleep` becomes 1. `pad_sleep` is always the inverse of that bit.
- R5: `sdn_active` stays high until `wake_rst` or `wake_io` is sampled high. While it is high, `wake_stby`, key writes and pad-control writes have no effect.
- R6: On leaving shutdown, flag bit 17 is set, flag bit 16 takes the value of `wake_io` in that cycle, the wakeup source becomes 1, and pad-control bit 0 stays 0.
- R7: Outside shutdown, writing 1 to pad-control bit 0 releases the pads and clears flag bits 17 and 16. Writing 0 latches the pads and leaves the flags unchanged.
- R8: Outside shutdown, `wake_rst` sets the wakeup source to 1 and `wake_stby` alone sets it to 2, with `wake_rst` winning if both are high. `wake_io` alone is ignored. The source only ever reads 1 or 2.
- R9: Word 0 always reads 0, and `bus_rdata` carries the addressed word in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| wake_stby | input | 1 | Wakeup from standby |
| wake_rst | input | 1 | Wakeup from reset or shutdown exit |
| wake_io | input | 1 | Wakeup caused by an IO event |
| sdn_req | output | 1 | One-cycle shutdown request pulse |
| sdn_active | output | 1 | Shutdown held until a wakeup |
| pad_sleep | output | 1 | 1 = IO pads latched in sleep |

## Verification
The assertions assume that wakeup inputs are sampled only at clock edges, and that a bus access and a wakeup may coincide in any combination. The stimulus holds each bus access and each wakeup pulse for exactly one cycle, and drives them at the falling edge. The bench sweeps every combination of the three wakeup inputs, both inside and outside shutdown. It also sweeps 510 near-miss key values that differ from the magic value in one byte, so that the invariants linking flags, pad state and source code are exercised across all of these transitions.

// File: rtl/pwr_sdn_pkg.sv
// Shared constants and encodings for the keyed shutdown controller.
package pwr_sdn_pkg;
    // Register word indices on the bus.
    typedef enum logic [1:0] {
        ADR_KEY   = 2'd0,
        ADR_PAD   = 2'd1,
        ADR_WSRC  = 2'd2,
        ADR_FLAGS = 2'd3
    } reg_addr_e;

    // Wakeup source codes.
    typedef enum logic [1:0] {
        WSRC_RST  = 2'd1,
        WSRC_STBY = 2'd2
    } wsrc_e;

    // Bit positions inside the flag word.
    localparam int unsigned FLAG_SD_POS = 17;
    localparam int unsigned FLAG_IO_POS = 16;
    localparam int unsigned WSRC_W      = 2;
endpackage

// File: rtl/pwr_key_gate.sv
// Key gate: compares the key-word write against the magic value and runs
// the shutdown state. Assumes key_wr lasts one cycle per access.
module pwr_key_gate #(
    parameter int unsigned    DATA_W  = 32,
    parameter int unsigned    KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'hA5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_rst,
    input  logic              wake_io,
    output logic              sdn_enter,
    output logic              sdn_exit,
    output logic              sdn_req,
    output logic              sdn_active
);
    localparam logic [DATA_W-1:0] KEY_MASK = {{(DATA_W-KEY_W){1'b0}}, {KEY_W{1'b1}}};
    localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(KEY_VAL);

    logic key_match;

    // Decode an accepted key and a qualifying wakeup.
    always_comb begin
        key_match = (wr_data & KEY_MASK) == KEY_WORD;
        sdn_enter = key_wr && key_match && !sdn_active;
        sdn_exit  = sdn_active && (wake_rst || wake_io);
    end

    // Pulse and held level of the shutdown request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdn_req    <= 1'b0;
            sdn_active <= 1'b0;
        end else begin
            sdn_req <= sdn_enter;
            if (sdn_enter)
                sdn_active <= 1'b1;
            else if (sdn_exit)
                sdn_active <= 1'b0;
        end
    end

    // R2
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdn_req |=> !sdn_req);
    // R2
    req_with_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdn_req |-> sdn_active);
    // R5
    active_leave_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdn_active) |-> $past(wake_rst || wake_io));
endmodule

// File: rtl/pwr_pad_latch.sv
// Pad latch: holds the pad-control bit (1 = pads live). Entry into shutdown
// forces it low; software writes are ignored while shutdown is held.
module pwr_pad_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sdn_enter,
    input  logic sdn_active,
    input  logic pad_wr,
    input  logic pad_wbit,
    output logic pad_live,
    output logic pad_release,
    output logic pad_sleep
);
    logic wr_ok;

    // Qualify software writes and detect a release.
    always_comb begin
        wr_ok       = pad_wr && !sdn_active;
        pad_release = wr_ok && pad_wbit;
        pad_sleep   = !pad_live;
    end

    // Pad-control bit: reset live, forced low on shutdown entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pad_live <= 1'b1;
        else if (sdn_enter)
            pad_live <= 1'b0;
        else if (wr_ok)
            pad_live <= pad_wbit;
    end

    // R4
    pads_held_in_sdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdn_active |-> !pad_live);
    // R4
    pads_sleep_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdn_active) |-> pad_sleep);
    // R5
    pad_frozen_in_sdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdn_active && pad_wr) |=> !pad_live);
endmodule

// File: rtl/pwr_wake_rec.sv
// Wake recorder: captures the wakeup source code and the shutdown-exit
// flags. Assumes exit and release never coincide (release needs !active).
module pwr_wake_rec
    import pwr_sdn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdn_active,
    input  logic              sdn_exit,
    input  logic              pad_release,
    input  logic              wake_stby,
    input  logic              wake_rst,
    input  logic              wake_io,
    output logic [WSRC_W-1:0] wsrc,
    output logic              sd_flag,
    output logic              io_flag
);
    // Shutdown-exit flags, cleared by pad release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_flag <= 1'b0;
            io_flag <= 1'b0;
        end else if (sdn_exit) begin
            sd_flag <= 1'b1;
            io_flag <= wake_io;
        end else if (pad_release) begin
            sd_flag <= 1'b0;
            io_flag <= 1'b0;
        end
    end

    // Wakeup source code, reset exit taking priority over standby.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wsrc <= WSRC_RST;
        else if (sdn_exit || (!sdn_active && wake_rst))
            wsrc <= WSRC_RST;
        else if (!sdn_active && wake_stby)
            wsrc <= WSRC_STBY;
    end

    // R6
    io_needs_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_flag |-> sd_flag);
    // R6
    sd_set_from_sdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_flag) |-> $past(sdn_active));
    // R8
    wsrc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wsrc == WSRC_RST) || (wsrc == WSRC_STBY));
    // R7
    flags_clear_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_release |=> (!sd_flag && !io_flag));
endmodule

// File: rtl/pwr_sdn_ctrl.sv
// Top: bus decode, registered read mux, and wiring of key gate, pad latch
// and wake recorder. Assumes DATA_W > 17 so the flag bits fit.
module pwr_sdn_ctrl
    import pwr_sdn_pkg::*;
#(
    parameter int unsigned      DATA_W  = 32,
    parameter int unsigned      ADDR_W  = 2,
    parameter int unsigned      KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'hA5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wake_stby,
    input  logic              wake_rst,
    input  logic              wake_io,
    output logic              sdn_req,
    output logic              sdn_active,
    output logic              pad_sleep
);
    localparam logic [DATA_W-1:0] PAD_MASK = DATA_W'(1);

    logic              key_wr, pad_wr, pad_wbit, rd_en;
    logic              sdn_enter, sdn_exit, pad_live, pad_release;
    logic              sd_flag, io_flag;
    logic [WSRC_W-1:0] wsrc;
    logic [DATA_W-1:0] rd_next;

    // Bus write decode.
    always_comb begin
        key_wr   = bus_valid && bus_write && (bus_addr == ADDR_W'(ADR_KEY));
        pad_wr   = bus_valid && bus_write && (bus_addr == ADDR_W'(ADR_PAD));
        pad_wbit = (bus_wdata & PAD_MASK) != '0;
        rd_en    = bus_valid && !bus_write;
    end

    pwr_key_gate #(
        .DATA_W (DATA_W),
        .KEY_W  (KEY_W),
        .KEY_VAL(KEY_VAL)
    ) key_gate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .wr_data   (bus_wdata),
        .wake_rst  (wake_rst),
        .wake_io   (wake_io),
        .sdn_enter (sdn_enter),
        .sdn_exit  (sdn_exit),
        .sdn_req   (sdn_req),
        .sdn_active(sdn_active)
    );

    pwr_pad_latch pad_latch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdn_enter  (sdn_enter),
        .sdn_active (sdn_active),
        .pad_wr     (pad_wr),
        .pad_wbit   (pad_wbit),
        .pad_live   (pad_live),
        .pad_release(pad_release),
        .pad_sleep  (pad_sleep)
    );

    pwr_wake_rec wake_rec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdn_active (sdn_active),
        .sdn_exit   (sdn_exit),
        .pad_release(pad_release),
        .wake_stby  (wake_stby),
        .wake_rst   (wake_rst),
        .wake_io    (wake_io),
        .wsrc       (wsrc),
        .sd_flag    (sd_flag),
        .io_flag    (io_flag)
    );

    // Read mux: the key word and unmapped words read as zero.
    always_comb begin
        rd_next = '0;
        if (bus_addr == ADDR_W'(ADR_PAD))
            rd_next[0] = pad_live;
        else if (bus_addr == ADDR_W'(ADR_WSRC))
            rd_next[WSRC_W-1:0] = wsrc;
        else if (bus_addr == ADDR_W'(ADR_FLAGS)) begin
            rd_next[FLAG_SD_POS] = sd_flag;
            rd_next[FLAG_IO_POS] = io_flag;
        end
    end

    // Registered read data, updated on read requests only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_en)
            bus_rdata <= rd_next;
    end

    // R9
    key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == ADDR_W'(ADR_KEY)) |=> (bus_rdata == '0));
endmodule

// File: tb/pwr_sdn_ctrl_tb.sv
module pwr_sdn_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wake_stby = 1'b0, wake_rst = 1'b0, wake_io = 1'b0;
    logic        sdn_req, sdn_active, pad_sleep;

    int errors = 0, checks = 0, pulses = 0;
    bit done = 1'b0;
    logic [1:0] exp_wsrc;

    always #5 clk = ~clk;

    pwr_sdn_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_stby(wake_stby), .wake_rst(wake_rst), .wake_io(wake_io),
        .sdn_req(sdn_req), .sdn_active(sdn_active), .pad_sleep(pad_sleep)
    );

    always @(posedge clk) if (rst_n && sdn_req) pulses++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wake(input bit s, input bit r, input bit i);
        wake_stby = s; wake_rst = r; wake_io = i;
        @(negedge clk);
        wake_stby = 1'b0; wake_rst = 1'b0; wake_io = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, tag, v, exp);
    endtask

    function automatic logic [31:0] flags(input bit sd, input bit io);
        return (32'(sd) << 17) | (32'(io) << 16);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!sdn_active && !sdn_req, "R1 sdn outputs", {sdn_active, sdn_req}, 0);
        chk(!pad_sleep, "R1 pad_sleep", pad_sleep, 0);
        rd_chk(2'd1, 32'd1, "R1 pad bit");
        rd_chk(2'd2, 32'd1, "R1 wsrc");
        rd_chk(2'd3, 32'd0, "R1 flags");
        rd_chk(2'd0, 32'd0, "R9 key word reads 0");
        exp_wsrc = 2'd1;

        // R3 near-miss key sweep over one byte at a time
        for (int h = 0; h < 2; h++) begin
            for (int b = 0; b < 256; b++) begin
                logic [15:0] k;
                logic [31:0] v;
                k = (h == 0) ? {b[7:0], 8'hA5} : {8'hA5, b[7:0]};
                if (k == 16'hA5A5) continue;
                base = pulses;
                wr(2'd0, {16'h0, k});
                rd(2'd1, v);
                chk(pulses == base && !sdn_active && !pad_sleep && v == 32'd1,
                    "R3 bad key ignored", {15'h0, k, sdn_active}, {16'h0, k, 1'b0});
            end
        end
        rd_chk(2'd3, 32'd0, "R3 flags untouched");

        // R2 accepted key with junk upper bits
        base = pulses;
        wr(2'd0, 32'hFFFF_A5A5);
        chk(sdn_req && sdn_active, "R2 pulse and active", {sdn_req, sdn_active}, 2'b11);
        chk(pad_sleep, "R4 pads latched on entry", pad_sleep, 1);
        @(negedge clk);
        chk(!sdn_req && sdn_active, "R2 pulse one cycle", {sdn_req, sdn_active}, 2'b01);
        chk(pulses == base + 1, "R2 pulse count", pulses, base + 1);
        rd_chk(2'd1, 32'd0, "R4 pad bit cleared");

        // R5 in shutdown: key, pad writes, standby wake ignored
        base = pulses;
        wr(2'd0, 32'h0000_A5A5);
        wr(2'd1, 32'd1);
        wake(1'b1, 1'b0, 1'b0);
        chk(pulses == base && sdn_active && pad_sleep, "R5 held in shutdown",
            {pulses == base, sdn_active, pad_sleep}, 3'b111);
        rd_chk(2'd2, 32'd1, "R5 wsrc unchanged by stby");
        rd_chk(2'd3, 32'd0, "R5 flags unchanged by pad write");
        wake(1'b0, 1'b1, 1'b0);
        rd_chk(2'd3, flags(1, 0), "R6 exit via rst");
        wr(2'd1, 32'd1);
        rd_chk(2'd3, 32'd0, "R7 flags cleared by release");

        // R6 sweep of all wake combinations inside shutdown
        for (int c = 0; c < 8; c++) begin
            bit s, r, i, ex;
            s = c[0]; r = c[1]; i = c[2];
            ex = r | i;
            wr(2'd0, 32'h0000_A5A5);
            wake(s, r, i);
            if (ex) exp_wsrc = 2'd1;
            chk(sdn_active == !ex, "R5/R6 active after wake", sdn_active, !ex);
            chk(pad_sleep, "R6 pads stay latched", pad_sleep, 1);
            rd_chk(2'd3, ex ? flags(1, i) : 32'd0, "R6 flags");
            rd_chk(2'd2, 32'(exp_wsrc), "R6 wsrc");
            if (!ex) begin
                wake(1'b0, 1'b1, 1'b0);
                exp_wsrc = 2'd1;
            end
            wr(2'd1, 32'd1);
            chk(!pad_sleep, "R7 release pads", pad_sleep, 0);
            rd_chk(2'd3, 32'd0, "R7 release clears flags");
        end

        // R8 sweep outside shutdown
        for (int c = 0; c < 8; c++) begin
            bit s, r, i;
            s = c[0]; r = c[1]; i = c[2];
            wake(s, r, i);
            if (r) exp_wsrc = 2'd1;
            else if (s) exp_wsrc = 2'd2;
            rd_chk(2'd2, 32'(exp_wsrc), "R8 wsrc");
            chk(!sdn_active && !pad_sleep, "R8 io ignored", {sdn_active, pad_sleep}, 0);
            rd_chk(2'd3, 32'd0, "R8 flags stay clear");
        end

        // R7 software latch then release, flags preserved across latch
        wr(2'd0, 32'h0000_A5A5);
        wake(1'b0, 1'b0, 1'b1);
        wr(2'd1, 32'd0);
        chk(pad_sleep, "R7 write 0 keeps latch", pad_sleep, 1);
        rd_chk(2'd3, flags(1, 1), "R7 write 0 keeps flags");
        wr(2'd1, 32'd1);
        wr(2'd1, 32'd0);
        chk(pad_sleep, "R7 write 0 latches", pad_sleep, 1);
        rd_chk(2'd1, 32'd0, "R7 pad bit 0");
        wr(2'd1, 32'd1);
        rd_chk(2'd1, 32'd1, "R7 pad bit 1");
        rd_chk(2'd0, 32'd0, "R9 key word reads 0 late");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule